// File: doc/BRIEF.md
# Pointer-Indexed Calendar Register Window

This block keeps a set of calendar time bytes and alarm bytes. Software reaches them through two 16-bit windows on a small word bus. Each window has a 2-bit pointer that picks which pair of bytes the window shows. After every access the pointer steps down by one, and it stops at zero. A routine can therefore load the pointer once and then reach the whole set with a run of accesses to the same address. Each pointer also has its own configuration word, so software can load it directly.

The bus carries a select, a write flag, a 2-bit address, 16-bit write data, and separate strobes for the high and low bytes. Read data is combinational from the current state. A pointer step, or a store into a byte, takes effect at the clock edge that ends the access. Writes to the time bytes through the window are gated by an external enable input. Alarm writes are not gated.

Top module: `calWindow`

## Requirements
- R1: After reset both pointers are 0 and every time and alarm byte is 0.
- R2: Address 0 is the time window. Pointer 0 shows {minutes, seconds}, 1 shows {weekday, hours}, 2 shows {month, day}, and 3 shows {unused, year}, with the high byte written first in each pair.
- R3: Address 1 is the alarm window. Pointer 0 shows {alarm minutes, alarm seconds}, 1 shows {alarm weekday, alarm hours}, 2 shows {alarm month, alarm day}, and 3 shows {power stability, power sample}.
- R4: A window write with the high strobe set stores the strobed bytes into the pair selected before the access. If that pointer is nonzero, the pointer then drops by one at the same edge.
- R5: A window write with only the low strobe set stores the low byte and leaves the pointer unchanged.
- R6: A window read with either strobe set returns the pair selected before the access, and the pointer drops by one at the end of the access.
- R7: A pointer at 0 stays at 0 on any window access until software loads a new value.
- R8: Address 2 is the time configuration word and address 3 is the alarm configuration word. Each holds its pointer in bits 9:8, and all other bits read as 0. A write with the high strobe loads bits 9:8 of the write data. A write with only the low strobe has no effect. Accesses to a configuration word never step a pointer.
- R9: The high byte at time pointer 3 always reads 0, and writes to it are discarded.
- R10: Time window writes store nothing while `timeWrEn` is low, but the pointer still steps. Alarm window writes do not depend on `timeWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | 0 time window, 1 alarm window, 2 time config, 3 alarm config |
| busByteHi | input | 1 | High byte strobe |
| busByteLo | input | 1 | Low byte strobe |
| busWdata | input | 16 | Write data |
| timeWrEn | input | 1 | Permits stores into the time bytes |
| busRdata | output | 16 | Read data for the addressed word |

## Verification
Read data is combinational, so a read returns its value during the access cycle, taken from the pointer and the bytes as they stand before that cycle's edge. A pointer step or a byte store becomes visible only in the cycle after the access. The bench drives each access at the falling edge and samples `busRdata` a short time later, before the next rising edge. It then checks each pointer step with a separate configuration-word read, or a window read, in a later access. This way every check sees exactly the edges that its requirement accounts for.

// File: rtl/calWindowPkg.sv
package calWindowPkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 2;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAIRS  = 1 << PTR_W;
  localparam int BYTES  = 2 * PAIRS;

  typedef enum logic [1:0] {
    SRC_TIME  = 2'd0,
    SRC_ALARM = 2'd1,
    SRC_TCFG  = 2'd2,
    SRC_ACFG  = 2'd3
  } rdSrcT;

  typedef struct packed {
    logic [PTR_W-1:0] timePtr;
    logic [PTR_W-1:0] alarmPtr;
    logic             timeWrHi;
    logic             timeWrLo;
    logic             alarmWrHi;
    logic             alarmWrLo;
    rdSrcT            rdSrc;
  } winStrobeT;
endpackage

// File: rtl/calWindowCtrl.sv
module calWindowCtrl
  import calWindowPkg::*;
#(
  parameter int PTR_BIT_LO = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [1:0]  busAddr,
  input  logic        busByteHi,
  input  logic        busByteLo,
  input  logic [WORD_W-1:0] busWdata,
  output winStrobeT   strb
);
  localparam int NWIN = 2;

  logic [PTR_W-1:0] ptrQ [NWIN];
  logic winHit [NWIN];
  logic cfgHit [NWIN];
  logic stepReq [NWIN];
  logic loadReq [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign winHit[w]  = busSel && (busAddr == 2'(w));
    assign cfgHit[w]  = busSel && (busAddr == 2'(w + NWIN));
    assign stepReq[w] = winHit[w] &&
                        (busWrite ? busByteHi : (busByteHi || busByteLo));
    assign loadReq[w] = cfgHit[w] && busWrite && busByteHi;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ptrQ[w] <= '0;
      else if (loadReq[w])
        ptrQ[w] <= busWdata[PTR_BIT_LO +: PTR_W];
      else if (stepReq[w] && (ptrQ[w] != '0))
        ptrQ[w] <= ptrQ[w] - 1'b1;
    end

    // R4 / R6: an access at a nonzero pointer steps it down by one
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rstN)
      (stepReq[w] && ptrQ[w] != '0) |=> (ptrQ[w] == $past(ptrQ[w]) - 1'b1));
    // R7: pointer at zero stays there on a window access
    assert_ptr_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
      (winHit[w] && ptrQ[w] == '0) |=> (ptrQ[w] == '0));
    // R5: a low-only window write leaves the pointer alone
    assert_lo_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      (winHit[w] && busWrite && busByteLo && !busByteHi) |=> $stable(ptrQ[w]));
    // R8: a configuration load takes bits 9:8 of the write data
    assert_cfg_load_R8: assert property (@(posedge clk) disable iff (!rstN)
      loadReq[w] |=> (ptrQ[w] == $past(busWdata[PTR_BIT_LO +: PTR_W])));
  end

  always_comb begin
    strb.timePtr   = ptrQ[0];
    strb.alarmPtr  = ptrQ[1];
    strb.timeWrHi  = winHit[0] && busWrite && busByteHi;
    strb.timeWrLo  = winHit[0] && busWrite && busByteLo;
    strb.alarmWrHi = winHit[1] && busWrite && busByteHi;
    strb.alarmWrLo = winHit[1] && busWrite && busByteLo;
    strb.rdSrc     = rdSrcT'(busAddr);
  end
endmodule

// File: rtl/calWindowData.sv
module calWindowData
  import calWindowPkg::*;
#(
  parameter int PTR_BIT_LO = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  winStrobeT   strb,
  input  logic        timeWrEn,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata
);
  localparam int UNUSED_IDX = BYTES - 1;

  logic [BYTE_W-1:0] timeByte  [BYTES];
  logic [BYTE_W-1:0] alarmByte [BYTES];

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    localparam int PAIR = i / 2;
    localparam bit ISHI = (i % 2) == 1;
    logic tEn, aEn;
    assign tEn = timeWrEn && (strb.timePtr == PTR_W'(PAIR)) &&
                 (ISHI ? strb.timeWrHi : strb.timeWrLo);
    assign aEn = (strb.alarmPtr == PTR_W'(PAIR)) &&
                 (ISHI ? strb.alarmWrHi : strb.alarmWrLo);

    if (i == UNUSED_IDX) begin : g_unused
      assign timeByte[i] = '0;
    end else begin : g_time
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     timeByte[i] <= '0;
        else if (tEn)  timeByte[i] <= busWdata[(ISHI ? BYTE_W : 0) +: BYTE_W];
      end
      // R10: nothing is stored into a time byte while the enable is low
      assert_time_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
        !timeWrEn |=> $stable(timeByte[i]));
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)     alarmByte[i] <= '0;
      else if (aEn)  alarmByte[i] <= busWdata[(ISHI ? BYTE_W : 0) +: BYTE_W];
    end
  end

  logic [WORD_W-1:0] timeWord, alarmWord;
  always_comb begin
    timeWord  = {timeByte[2*strb.timePtr + 1], timeByte[2*strb.timePtr]};
    alarmWord = {alarmByte[2*strb.alarmPtr + 1], alarmByte[2*strb.alarmPtr]};
    busRdata  = '0;
    unique case (strb.rdSrc)
      SRC_TIME:  busRdata = timeWord;
      SRC_ALARM: busRdata = alarmWord;
      SRC_TCFG:  busRdata[PTR_BIT_LO +: PTR_W] = strb.timePtr;
      SRC_ACFG:  busRdata[PTR_BIT_LO +: PTR_W] = strb.alarmPtr;
      default:   busRdata = '0;
    endcase
  end

  // R9: unused high byte of the time window reads zero
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSrc == SRC_TIME && strb.timePtr == PTR_W'(PAIRS - 1)) |->
      (busRdata[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/calWindow.sv
module calWindow
  import calWindowPkg::*;
#(
  parameter int PTR_BIT_LO = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [1:0]  busAddr,
  input  logic        busByteHi,
  input  logic        busByteLo,
  input  logic [15:0] busWdata,
  input  logic        timeWrEn,
  output logic [15:0] busRdata
);
  winStrobeT strb;

  calWindowCtrl #(.PTR_BIT_LO(PTR_BIT_LO)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteHi(busByteHi), .busByteLo(busByteLo),
    .busWdata(busWdata), .strb(strb)
  );

  calWindowData #(.PTR_BIT_LO(PTR_BIT_LO)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .timeWrEn(timeWrEn),
    .busWdata(busWdata), .busRdata(busRdata)
  );
endmodule

// File: tb/calWindow_tb.sv
module calWindow_tb;
  logic clk = 0;
  logic rstN = 0;
  logic busSel = 0, busWrite = 0, busByteHi = 0, busByteLo = 0, timeWrEn = 0;
  logic [1:0] busAddr = 0;
  logic [15:0] busWdata = 0;
  logic [15:0] busRdata;
  int nVec = 0, nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  calWindow u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busByteHi(busByteHi), .busByteLo(busByteLo),
    .busWdata(busWdata), .timeWrEn(timeWrEn), .busRdata(busRdata)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic        hi;
    logic        lo;
    logic        wen;
    logic [15:0] wdata;
    logic [15:0] expData;
    logic        chk;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 35;
  localparam vecT VEC [NV] = '{
    '{1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 1'b0, 4'd8},  // R8 load 3
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0300, 1'b1, 4'd8},  // R8 only 9:8
    '{1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 16'hAB24, 16'h0000, 1'b0, 4'd9},  // R9 year
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0200, 1'b1, 4'd4},  // R4 step
    '{1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 16'h1231, 16'h0000, 1'b0, 4'd2},
    '{1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 16'h0523, 16'h0000, 1'b0, 4'd2},
    '{1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 16'h5930, 16'h0000, 1'b0, 4'd7},
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd7},  // R7 floor
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0300, 16'h0000, 1'b0, 4'd8},
    '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0024, 1'b1, 4'd9},  // R9 zero hi
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h1231, 1'b1, 4'd6},  // R6 lo strobe
    '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0523, 1'b1, 4'd2},  // R2
    '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h5930, 1'b1, 4'd6},
    '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h5930, 1'b1, 4'd7},  // R7
    '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 16'h0300, 16'h0000, 1'b0, 4'd8},
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 16'h7755, 16'h0000, 1'b0, 4'd4},  // hi only
    '{1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 16'h6611, 16'h0000, 1'b0, 4'd5},  // R5 lo only
    '{1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0200, 1'b1, 4'd5},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0011, 1'b1, 4'd3},  // R3
    '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 16'h0608, 16'h0000, 1'b0, 4'd10}, // R10 alarm
    '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 16'h4515, 16'h0000, 1'b0, 4'd10},
    '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 16'h0300, 16'h0000, 1'b0, 4'd8},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h7700, 1'b1, 4'd3},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0011, 1'b1, 4'd3},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0608, 1'b1, 4'd10},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h4515, 1'b1, 4'd10},
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0000, 1'b0, 4'd8},
    '{1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 16'hEEEE, 16'h0000, 1'b0, 4'd10}, // gated
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd10}, // still steps
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0000, 1'b0, 4'd8},
    '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0523, 1'b1, 4'd10},
    '{1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 16'h0300, 16'h0000, 1'b0, 4'd8},  // lo-only cfg
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 1'b1, 4'd8},
    '{1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 16'h0007, 16'h0000, 1'b0, 4'd5},
    '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h5907, 1'b1, 4'd5}
  };

  task automatic access(input logic wr, input logic [1:0] addr, input logic hi,
                        input logic lo, input logic wen, input logic [15:0] wd,
                        input logic chk, input logic [15:0] expD, input int req);
    @(negedge clk);
    busSel = 1; busWrite = wr; busAddr = addr; busByteHi = hi; busByteLo = lo;
    timeWrEn = wen; busWdata = wd;
    #2;
    if (chk) begin
      nVec++;
      if (busRdata !== expD) begin
        nBad++;
        $display("FAIL R%0d: addr %0d read %h expected %h", req, addr, busRdata, expD);
      end
    end
    @(negedge clk);
    busSel = 0; busWrite = 0; busByteHi = 0; busByteLo = 0; timeWrEn = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    nVec++; nBad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state of pointers and storage
    access(0, 2'd2, 1, 1, 0, 16'h0, 1, 16'h0000, 1);
    access(0, 2'd3, 1, 1, 0, 16'h0, 1, 16'h0000, 1);
    access(0, 2'd0, 1, 1, 0, 16'h0, 1, 16'h0000, 1);
    access(0, 2'd1, 1, 1, 0, 16'h0, 1, 16'h0000, 1);
    for (int i = 0; i < NV; i++)
      access(VEC[i].wr, VEC[i].addr, VEC[i].hi, VEC[i].lo, VEC[i].wen,
             VEC[i].wdata, VEC[i].chk, VEC[i].expData, int'(VEC[i].req));
    // R1: mid-run reset clears storage and pointers
    access(1, 2'd3, 1, 0, 0, 16'h0200, 0, 16'h0, 1);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    access(0, 2'd3, 1, 1, 0, 16'h0, 1, 16'h0000, 1);
    access(0, 2'd0, 1, 1, 0, 16'h0, 1, 16'h0000, 1);
    access(0, 2'd1, 1, 1, 0, 16'h0, 1, 16'h0000, 1);
    finish_run();
  end
endmodule